// File: doc/BRIEF.md
# Accumulating Doorbell Mailbox

This block holds a doorbell vector that two agents share. The local processor is the only agent that sets bits. Each local write ORs its data into the vector, so the bits gather until the host collects them. The host bus master is the only agent that clears bits. A host read returns the gathered vector and empties it in the same step. The local processor can read the vector at any time without changing it, and so it can poll whether the host has taken the doorbell yet.

While the vector holds any set bit, the block raises an interrupt request toward the host. A separate disable input suppresses the request but leaves the vector as it is. Both read ports return their data on the clock after the read strobe. Each port keeps its last value until that port is read again. The bus protocols and the wider status words that carry the vector lie outside this block.

Top module: `doorbell_mailbox`

## Requirements
- R1: After a synchronous active-low reset, the vector is zero, both read-data outputs are zero and `host_irq` is low.
- R2: A local write with `loc_wr_en` high ORs `loc_wr_data` into the vector on the next clock edge. It never clears a bit that is already set.
- R3: A local read (`loc_rd_en` high) places the vector as it stood before the edge on `loc_rd_data` one cycle later. It leaves the vector unchanged.
- R4: A host read (`host_rd_en` high) places the vector as it stood before the edge on `host_rd_data` one cycle later. It clears the vector on that same edge.
- R5: When a local write and a host read happen in the same cycle, the host read returns the old vector. After that edge the vector holds only the newly written bits.
- R6: `host_irq` is high exactly when the vector is nonzero and `irq_off` is low. It falls in the cycle after a clearing host read that has no write beside it.
- R7: While `irq_off` is high, `host_irq` stays low and the vector keeps its bits. The request returns once `irq_off` falls again.
- R8: A local write of all zeros leaves the vector unchanged.
- R9: Each read-data output holds its last captured value until its own port is read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| loc_wr_en | input | 1 | Local write strobe |
| loc_wr_data | input | VEC_W | Bits to OR into the vector |
| loc_rd_en | input | 1 | Local non-destructive read strobe |
| loc_rd_data | output | VEC_W | Vector captured by the last local read |
| host_rd_en | input | 1 | Host clearing read strobe |
| host_rd_data | output | VEC_W | Vector captured by the last host read |
| irq_off | input | 1 | Suppresses the interrupt request |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
The bench builds the block with its default width of 16 bits. At that width it can drive patterns that reach the top and bottom bits, including an all-ones vector. It drives a write and a clearing read in the same cycle and checks that the read returns the old vector while the new bits survive. It also checks that the disable input hides the request without changing the vector, using a local read to see the vector.

// File: rtl/doorbell_pkg.sv
// Package: shared defaults and the next-state rule for the doorbell vector.
// Assumes: callers pass vectors no wider than DB_MAX_W bits.
package doorbell_pkg;
    localparam int DB_DEFAULT_W = 16;
    localparam int DB_MAX_W     = 64;

    // Next vector: a host read empties the vector first, then the write's bits are ORed in.
    function automatic logic [DB_MAX_W-1:0] db_next(
        input logic [DB_MAX_W-1:0] cur,
        input logic                clr,
        input logic                set_en,
        input logic [DB_MAX_W-1:0] set_bits
    );
        logic [DB_MAX_W-1:0] base;
        base = clr ? '0 : cur;
        return set_en ? (base | set_bits) : base;
    endfunction
endpackage

// File: rtl/doorbell_accum.sv
// Module: doorbell_accum
// Holds the doorbell vector. Local writes can only set bits. Host reads can only clear them.
// Assumes: clr and set may arrive in the same cycle; the set bits then survive.
module doorbell_accum
    import doorbell_pkg::*;
#(
    parameter int VEC_W = DB_DEFAULT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_bits,
    input  logic             clr,
    output logic [VEC_W-1:0] bell
);
    localparam int PAD_W = DB_MAX_W - VEC_W;

    logic [VEC_W-1:0] bell_q;
    logic [DB_MAX_W-1:0] next_wide;

    // Work out the next vector with the shared set/clear rule.
    always_comb begin
        next_wide = db_next({{PAD_W{1'b0}}, bell_q}, clr, set_en, {{PAD_W{1'b0}}, set_bits});
    end

    // Vector register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) bell_q <= '0;
        else        bell_q <= next_wide[VEC_W-1:0];
    end

    assign bell = bell_q;

    // R2/R8: without a clear, every bit that was set stays set.
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((bell_q & $past(bell_q)) == $past(bell_q)));

    // R5: after a clear, only the bits written in the same cycle remain.
    a_r5_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bell_q == ($past(set_en) ? $past(set_bits) : '0)));

    // R8: a write of zeros with no clear leaves the vector unchanged.
    a_r8_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (!set_en || set_bits == '0)) |=> $stable(bell_q));
endmodule

// File: rtl/doorbell_rd_port.sv
// Module: doorbell_rd_port
// Captures the vector into a holding register when its port is read.
// Assumes: any side effect of the read, such as a clear, is handled by the vector's owner.
module doorbell_rd_port #(
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [VEC_W-1:0] bell,
    output logic [VEC_W-1:0] rd_data
);
    // Holding register, loaded on a read and kept otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= bell;
    end

    // R3/R4: a read returns the vector as it stood before the edge.
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data == $past(bell)));

    // R9: without a read, the returned data holds.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/doorbell_irq.sv
// Module: doorbell_irq
// Raises the host request while any doorbell bit is set, unless the request is disabled.
// Assumes: the disable input is synchronous to clk; the output is combinational.
module doorbell_irq #(
    parameter int VEC_W = 16
) (
    input  logic [VEC_W-1:0] bell,
    input  logic             irq_off,
    output logic             irq
);
    // OR-reduce the vector and gate it with the disable input.
    always_comb begin
        irq = (|bell) && !irq_off;
    end
endmodule

// File: rtl/doorbell_mailbox.sv
// Module: doorbell_mailbox (top)
// A doorbell shared by a local processor, which sets bits, and a host, which clears them by reading.
// Assumes: single clock domain, synchronous active-low reset, reads return data one cycle later.
module doorbell_mailbox
    import doorbell_pkg::*;
#(
    parameter int VEC_W = DB_DEFAULT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_wr_en,
    input  logic [VEC_W-1:0] loc_wr_data,
    input  logic             loc_rd_en,
    output logic [VEC_W-1:0] loc_rd_data,
    input  logic             host_rd_en,
    output logic [VEC_W-1:0] host_rd_data,
    input  logic             irq_off,
    output logic             host_irq
);
    logic [VEC_W-1:0] bell;

    // Vector storage: set from the local side, cleared by host reads.
    doorbell_accum #(.VEC_W(VEC_W)) u_accum (
        .clk(clk), .rst_n(rst_n),
        .set_en(loc_wr_en), .set_bits(loc_wr_data),
        .clr(host_rd_en), .bell(bell)
    );

    // Local read port, with no side effect.
    doorbell_rd_port #(.VEC_W(VEC_W)) u_loc_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(loc_rd_en), .bell(bell), .rd_data(loc_rd_data)
    );

    // Host read port; the clear is applied inside the vector storage.
    doorbell_rd_port #(.VEC_W(VEC_W)) u_host_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(host_rd_en), .bell(bell), .rd_data(host_rd_data)
    );

    // Interrupt request toward the host.
    doorbell_irq #(.VEC_W(VEC_W)) u_irq (
        .bell(bell), .irq_off(irq_off), .irq(host_irq)
    );

    // R6: a clearing host read with no write beside it drops the request.
    a_r6_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && !loc_wr_en) |=> !host_irq);

    // R7: the disable input always holds the request low.
    a_r7_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        irq_off |-> !host_irq);

    // R6: a nonzero write with no clear raises the request when it is not disabled.
    a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr_en && loc_wr_data != '0 && !irq_off) |=> (host_irq || irq_off));

    // R3: a local read alone leaves the vector unchanged.
    a_r3_local_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd_en && !host_rd_en && !loc_wr_en) |=> $stable(bell));
endmodule

// File: tb/doorbell_mailbox_test.sv
// Bench for doorbell_mailbox: the driver pushes expected results into a queue and a monitor checks them.
module doorbell_mailbox_test;
    localparam int W = 16;

    typedef struct {
        int         due;
        int         kind;   // 0 host data, 1 local data, 2 irq
        logic [W-1:0] val;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loc_wr_en = 1'b0, loc_rd_en = 1'b0, host_rd_en = 1'b0, irq_off = 1'b0;
    logic [W-1:0] loc_wr_data = '0;
    logic [W-1:0] loc_rd_data, host_rd_data;
    logic host_irq;

    int checks = 0, failures = 0, cyc = 0;
    exp_t q[$];
    logic [W-1:0] m_bell = '0;
    logic [W-1:0] m_host = '0;
    logic [W-1:0] m_loc = '0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    doorbell_mailbox #(.VEC_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .loc_wr_en(loc_wr_en), .loc_wr_data(loc_wr_data),
        .loc_rd_en(loc_rd_en), .loc_rd_data(loc_rd_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .irq_off(irq_off), .host_irq(host_irq)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus. It updates the model and queues what the outputs should show next.
    task automatic step(input logic wr, input logic [W-1:0] wd, input logic lr,
                        input logic hr, input logic off, input string tag);
        logic [W-1:0] nb;
        @(negedge clk); #1;
        loc_wr_en = wr; loc_wr_data = wd; loc_rd_en = lr; host_rd_en = hr; irq_off = off;
        if (hr) m_host = m_bell;
        if (lr) m_loc = m_bell;
        nb = (hr ? '0 : m_bell) | (wr ? wd : '0);
        m_bell = nb;
        q.push_back('{cyc + 1, 0, m_host, {tag, " host_data"}});
        q.push_back('{cyc + 1, 1, m_loc, {tag, " loc_data"}});
        q.push_back('{cyc + 1, 2, {{(W-1){1'b0}}, ((|nb) && !off)}, {tag, " irq"}});
    endtask

    // Monitor: at each falling edge, compare every item that falls due in this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            case (e.kind)
                0: check(e.tag, host_rd_data, e.val);
                1: check(e.tag, loc_rd_data, e.val);
                default: check(e.tag, {{(W-1){1'b0}}, host_irq}, e.val);
            endcase
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 reset irq", {{(W-1){1'b0}}, host_irq}, '0);
        check("R1 reset host_data", host_rd_data, '0);
        check("R1 reset loc_data", loc_rd_data, '0);
        #1 rst_n = 1'b1;
        step(0, '0, 1, 0, 0, "R1 read after reset");
        step(1, 16'h0005, 0, 0, 0, "R2 R6 first write");
        step(1, 16'h0102, 1, 0, 0, "R2 accumulate");
        step(1, 16'h0000, 1, 0, 0, "R8 zero write");
        step(0, '0, 1, 0, 0, "R3 poll one");
        step(0, '0, 1, 0, 0, "R3 poll two");
        step(0, '0, 0, 1, 0, "R4 host read");
        step(0, '0, 1, 0, 0, "R4 R6 after clear");
        step(0, '0, 0, 0, 0, "R9 hold");
        step(1, 16'h8000, 0, 0, 1, "R7 masked write");
        step(0, '0, 1, 0, 1, "R7 vector kept");
        step(0, '0, 0, 0, 0, "R7 unmask");
        step(1, 16'h0011, 0, 1, 0, "R5 collide");
        step(0, '0, 1, 0, 0, "R5 new bits only");
        step(1, 16'hFFFF, 0, 0, 0, "R2 all ones");
        step(1, 16'h0001, 1, 0, 0, "R2 no clear on write");
        step(0, '0, 0, 1, 0, "R4 read all ones");
        step(0, '0, 1, 0, 0, "R6 empty after read");
        for (int i = 0; i < 8; i++) begin
            step(1, 16'h0001 << (2 * i), (i % 2) == 0, (i % 3) == 2, 0, "R2 R4 pattern");
        end
        step(0, '0, 1, 1, 0, "R3 R4 both reads");
        step(0, '0, 0, 0, 0, "R9 final hold");
        @(negedge clk); @(negedge clk);
        done = 1;
    end

    // Watchdog and the summary line.
    initial begin
        for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule